// File: doc/BRIEF.md
# Raster Timing Generator with Border Box and Display Window

This block produces the scan timing for a video output. A horizontal and a vertical counter step through each line and each field. From them the block derives the sync pulses, a border box, and an active display window nested inside that box. While the window is active, the block drives a word address into a frame store. That address starts each line from a field base and moves forward by a programmed pitch. The block handles progressive and interlaced scan, repeated scan lines, repeated pixels, and pixel sizes of one to four bytes. It can also blank the picture by painting the border colour over the whole box.

The host writes twelve registers through a simple write port. Each write lands in a shadow copy. The block copies every shadow into its working set only when a new field begins, so a field never shows a mix of old and new settings. The start of each field also raises a one-cycle strobe to the host.

Top module: `raster_timing`

## Requirements
- R1: Register 0 sets the frame size: clocks per line in bits [9:0] and lines per field in bits [25:16]. The horizontal count runs from 0 to clocks-1 and the vertical count from 0 to lines-1, so a field lasts clocks*lines pixel steps.
- R2: `hsync` is high during the first HSYNC_W pixels of every line, and `vsync` is high during the first VSYNC_W lines of every field.
- R3: Register 1 (horizontal) and register 2 (vertical) each hold a border start in bits [25:16] and a border stop in bits [9:0]. A position is inside the box when start <= count < stop on both axes. Inside the box and outside the window, `border_active` is high and `border_rgb` carries register 11 bits [23:0]. Elsewhere `border_rgb` is zero. `blank` is high whenever neither `border_active` nor `window_active` is high.
- R4: The window opens at the pixel given by register 4 bits [9:0] and at the start line taken from register 5. It is (register 3 bits [9:0])+1 words wide and (register 3 bits [19:10])+1 source lines tall. While the window is open, `fetch_addr` equals the line base plus the bytes consumed on that line divided by 4. In progressive mode the first line base is register 6.
- R5: Register 9 bits [3:2] give bytes per pixel minus one. Each pixel consumes that many bytes of the line's width.
- R6: After each source line, the line base advances by the width in words plus the modulo (register 3 bits [29:20]) minus one.
- R7: When register 9 bit 1 is set, each source line is shown on two consecutive raster lines with the same line base.
- R8: When register 8 bit 0 is set, each pixel is held for two pixel steps.
- R9: When register 10 bit 4 is set, fields alternate between short and long, and the first field after it is enabled is short. A long field takes its base from register 6 and its start line from register 5 bits [25:16]. A short field takes its base from register 7 and its start line from register 5 bits [9:0].
- R10: When register 8 bit 3 is set, the window is suppressed and the border covers the whole box.
- R11: Output is shown only while both register 9 bit 0 (display enable) and register 10 bit 8 (video enable) are set. Otherwise `blank` is high and `border_active` and `window_active` are low, while the sync pulses continue.
- R12: When register 9 bit 23 is set, the counters advance on every clock. When it is clear, they advance on every second clock, so a field takes twice as many clocks.
- R13: A register write has no effect on the outputs until the next field begins, at which point all twelve registers take effect together.
- R14: `retrace_irq` is high for exactly one clock, in the first cycle of each field, at count (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register index, 0 to 11 |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | No picture at this position |
| border_active | output | 1 | Position shows the border colour |
| window_active | output | 1 | Position shows a fetched pixel |
| fetch_addr | output | AW | Word address of the current pixel |
| border_rgb | output | 24 | Border colour while the border is active, else zero |
| retrace_irq | output | 1 | One-cycle strobe at the start of each field |

## Verification
The properties rely on the host programming a consistent raster. Frame totals must be larger than the sync widths, the field must be longer than one pixel, and the window must lie inside the border box. The window start line must be at least 1 and fall inside the field. Every configuration the stimulus writes meets these limits: a 24-by-16 raster with the box at 4..22 by 2..15 and the window near its upper left. Each register change is made early in a field, so it takes effect at the next field start.

// File: rtl/raster_timing.sv
module raster_timing #(
  parameter int CW       = 10,
  parameter int AW       = 24,
  parameter int HSYNC_W  = 2,
  parameter int VSYNC_W  = 1,
  parameter int DEF_HTOT = 858,
  parameter int DEF_VTOT = 262
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [31:0]   wr_data,
  output logic          hsync,
  output logic          vsync,
  output logic          blank,
  output logic          border_active,
  output logic          window_active,
  output logic [AW-1:0] fetch_addr,
  output logic [23:0]   border_rgb,
  output logic          retrace_irq
);
  localparam int NREG   = 12;
  localparam int BW     = CW + 4;
  localparam int R_TOT  = 0, R_HB = 1, R_VB = 2, R_SIZE = 3, R_HST = 4, R_VST = 5;
  localparam int R_BL   = 6, R_BS = 7, R_CFG = 8, R_MODE = 9, R_SYNC = 10, R_COL = 11;
  localparam logic [31:0]   TOT_RST = (32'(DEF_VTOT) << 16) | 32'(DEF_HTOT);
  localparam logic [CW-1:0] HSW = CW'(HSYNC_W);
  localparam logic [CW-1:0] VSW = CW'(VSYNC_W);

  logic [31:0]   shd [NREG];
  logic [31:0]   act [NREG];
  logic [CW-1:0] hcnt, vcnt, src_cnt;
  logic [BW-1:0] bcnt;
  logic [AW-1:0] line_base;
  logic          fld, vwin, rep, phase, ce_ph, irq_q;

  logic [CW-1:0] htot, vtot, hb_on, hb_off, vb_on, vb_off;
  logic [CW-1:0] win_w_m1, win_h_m1, modulo, hst, vst, vnext;
  logic [BW-1:0] wbytes;
  logic [AW-1:0] step;
  logic [2:0]    bytes;
  logic          pix_dbl, force_blank, disp_en, scan_dbl, full_rate, vid_en;
  logic          ce, h_end, v_end, en, in_box, adv;
  logic          unused_bits;

  assign htot     = act[R_TOT][CW-1:0];
  assign vtot     = act[R_TOT][16 +: CW];
  assign hb_on    = act[R_HB][16 +: CW];
  assign hb_off   = act[R_HB][CW-1:0];
  assign vb_on    = act[R_VB][16 +: CW];
  assign vb_off   = act[R_VB][CW-1:0];
  assign win_w_m1 = act[R_SIZE][CW-1:0];
  assign win_h_m1 = act[R_SIZE][10 +: CW];
  assign modulo   = act[R_SIZE][20 +: CW];
  assign hst      = act[R_HST][CW-1:0];
  assign vst      = fld ? act[R_VST][CW-1:0] : act[R_VST][16 +: CW];
  assign pix_dbl     = act[R_CFG][0];
  assign force_blank = act[R_CFG][3];
  assign disp_en     = act[R_MODE][0];
  assign scan_dbl    = act[R_MODE][1];
  assign full_rate   = act[R_MODE][23];
  assign vid_en      = act[R_SYNC][8];
  assign bytes       = {1'b0, act[R_MODE][3:2]} + 3'd1;

  assign unused_bits = ^{act[0], act[1], act[2], act[3], act[4], act[5],
                         act[6], act[7], act[8], act[9], act[10], act[11]};

  assign ce     = full_rate | ce_ph;
  assign h_end  = (hcnt == htot - CW'(1));
  assign v_end  = (vcnt == vtot - CW'(1));
  assign vnext  = vcnt + CW'(1);
  assign wbytes = (BW'(win_w_m1) + BW'(1)) << 2;
  assign step   = AW'(win_w_m1) + AW'(modulo);
  assign en     = disp_en & vid_en;
  assign in_box = (hcnt >= hb_on) && (hcnt < hb_off) && (vcnt >= vb_on) && (vcnt < vb_off);

  assign window_active = en && !force_blank && vwin && (hcnt >= hst) && (bcnt < wbytes);
  assign border_active = en && in_box && !window_active;
  assign blank         = !(window_active || border_active);
  assign hsync         = hcnt < HSW;
  assign vsync         = vcnt < VSW;
  assign fetch_addr    = line_base + AW'(bcnt[BW-1:2]);
  assign border_rgb    = border_active ? act[R_COL][23:0] : 24'h0;
  assign retrace_irq   = irq_q;
  assign adv           = window_active && (!pix_dbl || phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        shd[i] <= (i == R_TOT) ? TOT_RST : 32'h0;
        act[i] <= (i == R_TOT) ? TOT_RST : 32'h0;
      end
      hcnt      <= '0;
      vcnt      <= '0;
      src_cnt   <= '0;
      bcnt      <= '0;
      line_base <= '0;
      fld       <= 1'b0;
      vwin      <= 1'b0;
      rep       <= 1'b0;
      phase     <= 1'b0;
      ce_ph     <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      ce_ph <= full_rate ? 1'b0 : ~ce_ph;
      irq_q <= ce && h_end && v_end;
      if (wr_en && wr_idx < 4'(NREG))
        shd[wr_idx] <= wr_data;
      if (ce) begin
        if (h_end) begin
          hcnt  <= '0;
          bcnt  <= '0;
          phase <= 1'b0;
          if (v_end) begin
            vcnt    <= '0;
            vwin    <= 1'b0;
            rep     <= 1'b0;
            src_cnt <= '0;
            for (int i = 0; i < NREG; i++)
              act[i] <= shd[i];
            fld       <= shd[R_SYNC][4] ? ~fld : 1'b0;
            line_base <= (shd[R_SYNC][4] && !fld) ? shd[R_BS][AW-1:0] : shd[R_BL][AW-1:0];
          end else begin
            vcnt <= vnext;
            if (vwin) begin
              if (scan_dbl && !rep) begin
                rep <= 1'b1;
              end else begin
                rep       <= 1'b0;
                line_base <= line_base + step;
                src_cnt   <= src_cnt + CW'(1);
                if (src_cnt == win_h_m1)
                  vwin <= 1'b0;
              end
            end else if (vnext == vst) begin
              vwin <= 1'b1;
            end
          end
        end else begin
          hcnt <= hcnt + CW'(1);
          if (window_active)
            phase <= ~phase;
          if (adv)
            bcnt <= bcnt + BW'(bytes);
        end
      end
    end
  end
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk (
  input logic clk,
  input logic rst_n,
  input logic retrace_irq,
  input logic hsync,
  input logic vsync,
  input logic window_active,
  input logic border_active
);
  // R14
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retrace_irq |=> !retrace_irq);

  // R2
  irq_at_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retrace_irq |-> (hsync && vsync));

  // R2
  vsync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> retrace_irq);

  // R3
  region_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(window_active && border_active));

  // R4
  field_start_nowin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retrace_irq |-> !window_active);
endmodule

bind raster_timing raster_timing_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .retrace_irq(retrace_irq),
  .hsync(hsync),
  .vsync(vsync),
  .window_active(window_active),
  .border_active(border_active)
);

// File: tb/sim_raster_timing.sv
module sim_raster_timing;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [31:0] wr_data;
  logic        hsync, vsync, blank, border_active, window_active, retrace_irq;
  logic [23:0] fetch_addr;
  logic [23:0] border_rgb;

  int checks = 0;
  int failures = 0;
  int pos = 0;
  int last_len = 0;

  always #5 clk = ~clk;

  raster_timing #(
    .CW(10), .AW(24), .HSYNC_W(2), .VSYNC_W(1), .DEF_HTOT(24), .DEF_VTOT(16)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .hsync(hsync), .vsync(vsync), .blank(blank), .border_active(border_active),
    .window_active(window_active), .fetch_addr(fetch_addr), .border_rgb(border_rgb),
    .retrace_irq(retrace_irq)
  );

  // {offset[47:32], pad[31:29], {hs,vs,blank,border,win}[28:24], addr[23:0]}
  localparam logic [47:0] VEC [12] = '{
    {16'd0,   3'd0, 5'b11100, 24'h000000},
    {16'd2,   3'd0, 5'b01100, 24'h000000},
    {16'd24,  3'd0, 5'b10100, 24'h000000},
    {16'd29,  3'd0, 5'b00100, 24'h000000},
    {16'd77,  3'd0, 5'b00010, 24'h000000},
    {16'd102, 3'd0, 5'b00001, 24'h000100},
    {16'd104, 3'd0, 5'b00001, 24'h000101},
    {16'd106, 3'd0, 5'b00010, 24'h000000},
    {16'd127, 3'd0, 5'b00001, 24'h000102},
    {16'd153, 3'd0, 5'b00001, 24'h000105},
    {16'd174, 3'd0, 5'b00010, 24'h000000},
    {16'd262, 3'd0, 5'b00100, 24'h000000}
  };

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %0h expected %0h (pos %0d)", req, what, got, exp, pos);
    end
  endtask

  task automatic step();
    @(negedge clk);
    pos++;
  endtask

  task automatic wr(input logic [3:0] i, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = i; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic next_field();
    int guard = 0;
    do begin
      step();
      guard++;
    end while (!retrace_irq && guard < 5000);
    if (!retrace_irq) chk("R14", "field start seen", 32'd0, 32'd1);
    last_len = pos;
    pos = 0;
  endtask

  task automatic goto(input int n);
    while (pos < n) step();
  endtask

  task automatic at(input int h, input int v);
    goto(v * 24 + h);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R14", "irq in reset", retrace_irq, 0);
    chk("R2", "hsync in reset", hsync, 1);
    chk("R2", "vsync in reset", vsync, 1);
    chk("R11", "blank in reset", blank, 1);
    chk("R11", "border in reset", border_active, 0);
    chk("R11", "window in reset", window_active, 0);
    chk("R3", "colour in reset", border_rgb, 0);
    rst_n = 1'b1;

    wr(0, 32'h0010_0018);
    wr(1, 32'h0004_0016);
    wr(2, 32'h0002_000F);
    wr(3, 32'h0010_0801);
    wr(4, 32'h0000_0006);
    wr(5, 32'h0004_0004);
    wr(6, 32'h0000_0100);
    wr(7, 32'h0000_0200);
    wr(8, 32'h0000_0000);
    wr(9, 32'h0080_0005);
    wr(10, 32'h0000_0100);
    wr(11, 32'h00AB_CDEF);
    next_field();

    chk("R14", "irq at field start", retrace_irq, 1);
    for (int k = 0; k < 12; k++) begin
      goto(int'(VEC[k][47:32]));
      chk("R2", "hsync", hsync, VEC[k][28]);
      chk("R2", "vsync", vsync, VEC[k][27]);
      chk("R3", "blank", blank, VEC[k][26]);
      chk("R3", "border", border_active, VEC[k][25]);
      chk("R4", "window", window_active, VEC[k][24]);
      if (VEC[k][24]) chk("R4", "fetch addr", fetch_addr, VEC[k][23:0]);
    end
    chk("R14", "irq mid field", retrace_irq, 0);
    next_field();
    chk("R1", "field length", last_len, 384);

    // R13 deferral and R10 forced blank
    wr(8, 32'h0000_0008);
    at(6, 4);
    chk("R13", "window before field start", window_active, 1);
    next_field();
    at(6, 4);
    chk("R10", "window forced off", window_active, 0);
    chk("R10", "border over window", border_active, 1);
    chk("R10", "not blank", blank, 0);
    chk("R3", "border colour", border_rgb, 32'h00AB_CDEF);

    // R8 pixel doubling
    wr(8, 32'h0000_0001);
    next_field();
    at(8, 4);
    chk("R8", "addr h8", fetch_addr, 24'h100);
    at(10, 4);
    chk("R8", "window h10", window_active, 1);
    chk("R8", "addr h10", fetch_addr, 24'h101);
    at(14, 4);
    chk("R8", "window end h14", window_active, 0);

    // R7 scan doubling
    wr(8, 32'h0000_0000);
    wr(9, 32'h0080_0007);
    next_field();
    at(6, 5);
    chk("R7", "repeat line addr", fetch_addr, 24'h100);
    at(6, 6);
    chk("R7", "second source line", fetch_addr, 24'h102);
    at(6, 9);
    chk("R7", "third source repeat", fetch_addr, 24'h104);
    at(6, 10);
    chk("R7", "window closed", window_active, 0);

    // R5 three bytes per pixel
    wr(9, 32'h0080_0009);
    next_field();
    at(8, 4);
    chk("R5", "window h8", window_active, 1);
    chk("R5", "addr h8", fetch_addr, 24'h101);
    at(9, 4);
    chk("R5", "window end h9", window_active, 0);

    // R9 interlace, R6 modulo
    wr(9, 32'h0080_0005);
    wr(10, 32'h0000_0110);
    wr(3, 32'h0030_0801);
    wr(5, 32'h0004_0005);
    next_field();
    at(6, 4);
    chk("R9", "short field not yet open", window_active, 0);
    at(6, 5);
    chk("R9", "short field base", fetch_addr, 24'h200);
    at(6, 6);
    chk("R6", "modulo step", fetch_addr, 24'h204);
    next_field();
    at(6, 4);
    chk("R9", "long field base", fetch_addr, 24'h100);
    at(6, 5);
    chk("R6", "long field step", fetch_addr, 24'h104);

    // R11 video enable off, then display enable off
    wr(10, 32'h0000_0000);
    wr(3, 32'h0010_0801);
    wr(5, 32'h0004_0004);
    next_field();
    at(1, 3);
    chk("R11", "sync continues", hsync, 1);
    at(6, 4);
    chk("R11", "blank video off", blank, 1);
    chk("R11", "window video off", window_active, 0);
    chk("R11", "border video off", border_active, 0);
    wr(10, 32'h0000_0100);
    wr(9, 32'h0080_0004);
    next_field();
    at(6, 4);
    chk("R11", "blank display off", blank, 1);
    chk("R11", "window display off", window_active, 0);

    // R12 half rate
    wr(9, 32'h0000_0005);
    next_field();
    goto(1);
    chk("R12", "hsync held", hsync, 1);
    goto(4);
    chk("R12", "hsync after two pixels", hsync, 0);
    goto(203);
    chk("R12", "before window", window_active, 0);
    goto(204);
    chk("R12", "window at half rate", window_active, 1);
    chk("R12", "addr at half rate", fetch_addr, 24'h100);
    next_field();
    chk("R12", "field length half rate", last_len, 768);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule